// File: doc/BRIEF.md
# Two-Channel Interpolating Audio PWM

This block turns a stream of stereo PCM samples into two pulse-width-modulated pins, one for each channel. Each incoming sample is signed two's complement, between 16 and 32 bits wide. The block keeps only its most significant bits, down to a chosen PWM resolution of 8 to 11 bits, and shifts the result into an unsigned duty value.

Between two successive samples the block inserts intermediate duty values by straight-line interpolation. This raises the update rate by a ratio of 2, 4, 6, 8 or 16. Every interpolated value lasts one PWM period of 2^R clock cycles. After the full run of periods for one sample, the next buffered sample is taken. If none has arrived, the last value is held.

The input side is a valid/ready stream with a single-entry buffer. The input sample rate is at most 16 kHz. The system clock and the ratio must be chosen so that a full interpolation run takes at least one input sample interval.

Top module: `apwm_interp2ch`

## Requirements
- R1: During reset and after it, `in_ready` is 1 and both pins are low while reset is held. The stored samples start at signed zero, so the first block of periods has duty 2^(R-1).
- R2: With `cfg_width` = W (16..32), the duty source is input bits [W-1:W-R] read as a signed R-bit number. Its MSB is then inverted, which is the same as adding 2^(R-1).
- R3: R = 8 + `cfg_res` (0..3 gives 8..11 bits). A PWM period lasts exactly 2^R clocks, and in each period the pin is high for exactly v cycles, where v is that period's duty value.
- R4: The `cfg_osr` codes are 0→2, 1→4, 2→6, 3→8 and 4→16; codes 5..7 act as 2. For ratio N and step k (0..N-1), with unsigned endpoints u0 and u1, the duty is floor((u0·(N−k) + u1·k)/N).
- R5: Ratio 6 gives the exact floor quotient for every pair of endpoints at every resolution.
- R6: One sample pair is buffered. `in_ready` is 1 exactly when the buffer is empty. A sample is taken on a clock edge where `in_valid` and `in_ready` are both 1. The buffer is emptied into the current endpoint at the end of the N-th period of each block.
- R7: If the buffer is empty when a block ends, the old end value becomes both endpoints, so the last value repeats until a new sample arrives.
- R8: Both channels share period and step timing and are computed independently from their own samples.
- R9: Input bits at or above position W do not affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 6 | Input sample width W, 16..32 |
| cfg_res | input | 2 | PWM resolution select, R = 8 + value |
| cfg_osr | input | 3 | Interpolation ratio code |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Buffer empty, sample pair will be taken |
| in_left | input | IN_W | Left channel PCM sample |
| in_right | input | IN_W | Right channel PCM sample |
| pwm_left | output | 1 | Left channel PWM pin |
| pwm_right | output | 1 | Right channel PWM pin |

## Verification
The assertions assume the three configuration inputs only change while reset is held. They also assume `cfg_width` never falls below R and never exceeds IN_W. The bench applies each configuration only inside a reset pulse and uses widths of 16, 20, 24 and 32 bits. It holds a sample offer until it is taken, in keeping with the handshake the assertions rely on. One run offers samples rarely so that the repeat-on-underrun path is exercised.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    localparam int MAX_RATIO   = 16;
    localparam int RATIO_W     = $clog2(MAX_RATIO) + 1;
    localparam int STEP_W      = $clog2(MAX_RATIO);
    localparam int RECIP_SHIFT = 18;
    localparam int RECIP6      = ((1 << RECIP_SHIFT) + 5) / 6;

    function automatic logic [RATIO_W-1:0] osr_ratio(input logic [2:0] sel);
        case (sel)
            3'd1:    return RATIO_W'(4);
            3'd2:    return RATIO_W'(6);
            3'd3:    return RATIO_W'(8);
            3'd4:    return RATIO_W'(16);
            default: return RATIO_W'(2);
        endcase
    endfunction

endpackage

// File: rtl/apwm_fmt.sv
module apwm_fmt #(
    parameter int IN_W    = 32,
    parameter int RES_MAX = 11
) (
    input  logic [IN_W-1:0]    raw,
    input  logic [5:0]         width,
    input  logic [3:0]         res_n,
    output logic [RES_MAX-1:0] trunc
);
    localparam int SH_W = $clog2(IN_W + 1);

    logic [IN_W-1:0]    shifted;
    logic [RES_MAX-1:0] mask;
    logic [SH_W-1:0]    shamt;

    always_comb begin
        shamt   = SH_W'(width - {2'b00, res_n});
        shifted = raw >> shamt;
        mask    = (RES_MAX'(1) << res_n) - RES_MAX'(1);
        trunc   = shifted[RES_MAX-1:0] & mask;
    end

endmodule

// File: rtl/apwm_lerp.sv
module apwm_lerp
    import apwm_pkg::*;
#(
    parameter int RES_MAX = 11
) (
    input  logic [RES_MAX-1:0] s0,
    input  logic [RES_MAX-1:0] s1,
    input  logic [3:0]         res_n,
    input  logic [STEP_W-1:0]  step,
    input  logic [2:0]         osr_sel,
    output logic [RES_MAX-1:0] duty
);
    localparam int XW = RES_MAX + RATIO_W;
    localparam int PW = XW + 18;

    logic [RES_MAX-1:0] half, u0, u1;
    logic [RATIO_W-1:0] nrat;
    logic [XW-1:0]      w0, w1, x;
    logic [PW-1:0]      prod;
    logic [XW-1:0]      q;

    always_comb begin
        half = RES_MAX'(1) << (res_n - 4'd1);
        u0   = s0 ^ half;
        u1   = s1 ^ half;
        nrat = osr_ratio(osr_sel);
        w0   = XW'(nrat) - XW'(step);
        w1   = XW'(step);
        x    = XW'(u0) * w0 + XW'(u1) * w1;
        prod = PW'(x) * PW'(RECIP6);
        case (nrat)
            RATIO_W'(4):  q = x >> 2;
            RATIO_W'(6):  q = XW'(prod >> RECIP_SHIFT);
            RATIO_W'(8):  q = x >> 3;
            RATIO_W'(16): q = x >> 4;
            default:      q = x >> 1;
        endcase
        duty = q[RES_MAX-1:0];
    end

endmodule

// File: rtl/apwm_interp2ch.sv
module apwm_interp2ch
    import apwm_pkg::*;
#(
    parameter int IN_W    = 32,
    parameter int RES_MAX = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [5:0]      cfg_width,
    input  logic [1:0]      cfg_res,
    input  logic [2:0]      cfg_osr,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [IN_W-1:0] in_left,
    input  logic [IN_W-1:0] in_right,
    output logic            pwm_left,
    output logic            pwm_right
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [RES_MAX-1:0]          cnt;
        logic [STEP_W-1:0]           k;
        logic                        pv;
        logic [NCH-1:0][RES_MAX-1:0] pend;
        logic [NCH-1:0][RES_MAX-1:0] s0;
        logic [NCH-1:0][RES_MAX-1:0] s1;
        logic [NCH-1:0]              pwm;
    } st_t;

    st_t st_d, st_q;

    logic [3:0]                  res_n;
    logic [RES_MAX-1:0]          last_cnt;
    logic [RATIO_W-1:0]          nrat;
    logic                        period_end, block_end;
    logic [NCH-1:0][IN_W-1:0]    raw;
    logic [NCH-1:0][RES_MAX-1:0] fmt_v, duty_v;

    assign res_n    = 4'd8 + {2'b00, cfg_res};
    assign last_cnt = (RES_MAX'(1) << res_n) - RES_MAX'(1);
    assign nrat     = osr_ratio(cfg_osr);
    assign raw[0]   = in_left;
    assign raw[1]   = in_right;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        apwm_fmt #(.IN_W(IN_W), .RES_MAX(RES_MAX)) u_fmt (
            .raw  (raw[c]),
            .width(cfg_width),
            .res_n(res_n),
            .trunc(fmt_v[c])
        );
        apwm_lerp #(.RES_MAX(RES_MAX)) u_lerp (
            .s0     (st_q.s0[c]),
            .s1     (st_q.s1[c]),
            .res_n  (res_n),
            .step   (st_q.k),
            .osr_sel(cfg_osr),
            .duty   (duty_v[c])
        );

        logic [RES_MAX-1:0] half_c, lo_c, hi_c;
        assign half_c = RES_MAX'(1) << (res_n - 4'd1);
        assign lo_c   = ((st_q.s0[c] ^ half_c) < (st_q.s1[c] ^ half_c)) ?
                        (st_q.s0[c] ^ half_c) : (st_q.s1[c] ^ half_c);
        assign hi_c   = ((st_q.s0[c] ^ half_c) < (st_q.s1[c] ^ half_c)) ?
                        (st_q.s1[c] ^ half_c) : (st_q.s0[c] ^ half_c);

        // R4
        lerp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_v[c] >= lo_c) && (duty_v[c] <= hi_c));
    end

    always_comb begin
        st_d       = st_q;
        period_end = (st_q.cnt == last_cnt);
        block_end  = period_end && (RATIO_W'(st_q.k) == nrat - RATIO_W'(1));

        st_d.cnt = period_end ? '0 : st_q.cnt + RES_MAX'(1);
        if (period_end) begin
            st_d.k = block_end ? '0 : st_q.k + STEP_W'(1);
        end
        if (block_end) begin
            st_d.s0 = st_q.s1;
            if (st_q.pv) begin
                st_d.s1 = st_q.pend;
                st_d.pv = 1'b0;
            end
        end
        if (in_valid && !st_q.pv) begin
            st_d.pend = fmt_v;
            st_d.pv   = 1'b1;
        end
        for (int c = 0; c < NCH; c++) begin
            st_d.pwm[c] = (st_q.cnt < duty_v[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = !st_q.pv;
    assign pwm_left  = st_q.pwm[0];
    assign pwm_right = st_q.pwm[1];

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == last_cnt) |=> (st_q.cnt == '0));

    // R4
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        RATIO_W'(st_q.k) < nrat);

    // R6
    accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R7
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((st_q.cnt == last_cnt) && (RATIO_W'(st_q.k) == nrat - RATIO_W'(1)))
        |=> $stable(st_q.s1));

endmodule

// File: tb/apwm_interp2ch_test.sv
module apwm_interp2ch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_width = 6'd16;
    logic [1:0]  cfg_res = 2'd0;
    logic [2:0]  cfg_osr = 3'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_left = '0, in_right = '0;
    logic        pwm_left, pwm_right;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    apwm_interp2ch uut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_res(cfg_res),
        .cfg_osr(cfg_osr), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right),
        .pwm_left(pwm_left), .pwm_right(pwm_right)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fmt(input int unsigned x, input int w, input int r);
        return int'((x >> (w - r)) & ((32'd1 << r) - 1));
    endfunction

    function automatic int ratio(input int sel);
        case (sel)
            1: return 4;
            2: return 6;
            3: return 8;
            4: return 16;
            default: return 2;
        endcase
    endfunction

    function automatic int lerp(input int s0, input int s1, input int r, input int n, input int k);
        int h = 1 << (r - 1);
        int u0 = s0 ^ h;
        int u1 = s1 ^ h;
        return (u0 * (n - k) + u1 * k) / n;
    endfunction

    function automatic int unsigned pick(input int w, input bit garbage);
        int unsigned x;
        int sel = $urandom % 8;
        if (sel == 0)      x = (32'd1 << (w - 1)) - 1;
        else if (sel == 1) x = 32'd1 << (w - 1);
        else               x = $urandom;
        if (w < 32) begin
            if (garbage) x = (x & ((32'd1 << w) - 1)) | ($urandom << w);
            else         x = x & ((32'd1 << w) - 1);
        end
        return x;
    endfunction

    task automatic run(input int w, input int r, input int osel, input int nper,
                       input int vprob, input bit garbage, input string tag);
        int n = ratio(osel);
        int per = 1 << r;
        int m_s0[2], m_s1[2], m_pend[2];
        int m_k = 0;
        bit m_pv = 0, m_rep = 0, cur_v = 0;
        int unsigned cur_x[2];
        in_valid = 1'b0;
        rst_n = 1'b0;
        cfg_width = 6'(w);
        cfg_res = 2'(r - 8);
        cfg_osr = 3'(osel);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset outputs
        chk("R1", int'(in_ready), 1);
        chk("R1", int'(pwm_left | pwm_right), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin m_s0[c] = 0; m_s1[c] = 0; m_pend[c] = 0; end
        for (int p = 0; p < nper; p++) begin
            int ev[2], hi[2];
            for (int c = 0; c < 2; c++) begin ev[c] = lerp(m_s0[c], m_s1[c], r, n, m_k); hi[c] = 0; end
            for (int i = 0; i < per; i++) begin
                bit acc;
                if (!cur_v && ($urandom % 1024) < vprob) begin
                    cur_v = 1;
                    cur_x[0] = pick(w, garbage);
                    cur_x[1] = pick(w, garbage);
                end
                in_valid = cur_v;
                in_left  = cur_x[0];
                in_right = cur_x[1];
                // R6 ready mirrors empty buffer
                if (in_ready !== !m_pv) chk("R6", int'(in_ready), int'(!m_pv));
                else nchk++;
                acc = cur_v && in_ready;
                @(posedge clk);
                #1;
                hi[0] += int'(pwm_left);
                hi[1] += int'(pwm_right);
                if (i == per - 1) begin
                    if (m_k == n - 1) begin
                        m_k = 0;
                        for (int c = 0; c < 2; c++) m_s0[c] = m_s1[c];
                        if (m_pv) begin
                            for (int c = 0; c < 2; c++) m_s1[c] = m_pend[c];
                            m_pv = 0;
                            m_rep = 0;
                        end else m_rep = 1;
                    end else m_k++;
                end
                if (acc) begin
                    m_pend[0] = fmt(cur_x[0], w, r);
                    m_pend[1] = fmt(cur_x[1], w, r);
                    m_pv = 1;
                    cur_v = 0;
                end
            end
            for (int c = 0; c < 2; c++) begin
                string t;
                if (p < n)      t = "R1";
                else if (m_rep) t = "R7";
                else if (c == 1) t = "R8";
                else            t = tag;
                chk(t, hi[c], ev[c]);
            end
        end
        in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run(16, 8,  0, 40, 64,  0, "R2");
        run(24, 10, 2, 36, 16,  0, "R5");
        run(32, 11, 1, 16, 8,   0, "R3");
        run(20, 9,  4, 64, 32,  1, "R9");
        run(32, 8,  3, 64, 1,   0, "R7");
        run(16, 8,  4, 48, 300, 1, "R4");
        run(20, 8,  6, 20, 64,  0, "R4");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule